// File: doc/BRIEF.md
# Ping-Pong Block De-Interleaver

This block rebuilds 11-bit protected audio samples from a serial stream of already descrambled payload bits. The bits of one block land in one of two storage banks. Bit k of a block goes to word k mod 64, at bit position k / 64. This placement undoes the bit-level spreading applied at the sender. The samples are not yet error-corrected; range expansion and concealment happen in later stages.

A block-boundary pulse from the frame logic swaps the roles of the two banks, but only when the bank being written holds a complete block. The bank just filled becomes the read bank. Its 64 words are then handed out one per read-enable pulse, in a fixed scrambled order that a constant address table supplies. Meanwhile the other bank takes the next block. Output words carry an ident bit that marks channel A or channel B. A one-cycle ready flag announces each swap.

Top module: `deint_pingpong`

## Requirements
- R1: Bit k (k = 0 for the first bit after a boundary) of a block is stored in word k mod 64, at bit position k / 64, where position 0 is the least significant bit of the output word.
- R2: Two banks alternate: the bank being read is never the bank being written, and bits of the next block written during read-out leave the words being read unchanged.
- R3: The j-th word read from a block (j = 0..63) is the stored word at address (23*j + 5) mod 64.
- R4: `chan_b` is 0 (channel A) for even j and 1 (channel B) for odd j.
- R5: Each `rd_en` cycle with words remaining yields exactly one word, with `word_valid` high for one cycle in the cycle after `rd_en`. Once all 64 words of a block have been read, `rd_en` gives no word until the next swap.
- R6: `blk_start` arriving while the write bank holds exactly 704 bits swaps the banks, and `blk_ready` is high for exactly the one cycle after that `blk_start`.
- R7: No word is emitted before the first complete block. A `blk_start` on a partial block does not swap and does not raise `blk_ready`; it only restarts the write count in the same bank.
- R8: Bits that arrive after the 704th bit of a block are ignored.
- R9: After reset, `word_out`, `word_valid`, `chan_b` and `blk_ready` are all 0.
- R10: A bit presented in the same cycle as `blk_start` becomes bit 0 of the new block.
- R11: A swap during read-out abandons the old block and restarts reading at j = 0 from the newly filled bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A payload bit is present this cycle |
| bit_in | input | 1 | Payload bit value |
| blk_start | input | 1 | Block boundary pulse |
| rd_en | input | 1 | Request one output word |
| word_out | output | 11 | De-interleaved sample word |
| word_valid | output | 1 | `word_out` holds a new word |
| chan_b | output | 1 | Ident: 0 = channel A, 1 = channel B |
| blk_ready | output | 1 | One-cycle pulse on a bank swap |

## Verification
A bit is taken on the clock edge where it is presented. A word requested by `rd_en` appears after that same edge, with `word_valid`, so it is due one cycle later. `blk_ready` follows its accepted `blk_start` by the same single register. The bench drives inputs between edges, advances one edge per step, and samples a short delay after that edge. Each step therefore checks exactly the cycle in which the requirement says its result appears, and checks that the flags are low in the cycles around it.

// File: rtl/deint_pkg.sv
package deint_pkg;

    localparam int SAMPLE_W    = 11;
    localparam int BLOCK_WORDS = 64;
    localparam int IL_STRIDE   = 23;
    localparam int IL_OFFSET   = 5;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // Read-order permutation; stride must be coprime with depth.
    function automatic int unsigned il_addr(
        input int unsigned idx,
        input int unsigned depth,
        input int unsigned stride,
        input int unsigned offset
    );
        return (idx * stride + offset) % depth;
    endfunction

endpackage

// File: rtl/deint_wr_ctrl.sv
module deint_wr_ctrl
    import deint_pkg::*;
#(
    parameter  int WORD_W = SAMPLE_W,
    parameter  int DEPTH  = BLOCK_WORDS,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_valid,
    input  logic          bit_in,
    input  logic          blk_start,
    output logic          wr_en,
    output logic          wr_bank_sel,
    output logic [AW-1:0] wr_word,
    output logic [PW-1:0] wr_pos,
    output logic          wr_val,
    output logic          cur_bank,
    output logic          swap
);
    localparam int BITS = WORD_W * DEPTH;
    localparam int CW   = $clog2(BITS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] idx;
    logic          full;

    assign full = (cnt == CW'(BITS));
    assign swap = blk_start && full;

    always_comb begin
        idx         = blk_start ? '0 : cnt;
        wr_en       = bit_valid && (blk_start || !full);
        wr_bank_sel = swap ? ~cur_bank : cur_bank;
        wr_word     = AW'(idx % CW'(DEPTH));
        wr_pos      = PW'(idx / CW'(DEPTH));
        wr_val      = bit_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            cur_bank <= 1'b0;
        end else if (blk_start) begin
            if (full) begin
                cur_bank <= ~cur_bank;
            end
            cnt <= bit_valid ? CW'(1) : '0;
        end else if (bit_valid && !full) begin
            cnt <= cnt + CW'(1);
        end
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(BITS));

    // R8
    no_count_past_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !blk_start) |=> full);

    // R7
    partial_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (blk_start && !full) |=> $stable(cur_bank));

endmodule

// File: rtl/deint_bank_store.sv
module deint_bank_store
    import deint_pkg::*;
#(
    parameter  int WORD_W = SAMPLE_W,
    parameter  int DEPTH  = BLOCK_WORDS,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_bank_sel,
    input  logic [AW-1:0]     wr_word,
    input  logic [PW-1:0]     wr_pos,
    input  logic              wr_val,
    input  logic              rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] bank_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank_sel == 1'(g))) begin
                mem[wr_word][wr_pos] <= wr_val;
            end
        end

        assign bank_rd[g] = mem[rd_addr];
    end

    assign rd_data = bank_rd[rd_bank];

    // R1
    pos_in_range_chk: assert property (@(posedge clk)
        wr_en |-> (int'(wr_pos) < WORD_W));

endmodule

// File: rtl/deint_rd_seq.sv
module deint_rd_seq
    import deint_pkg::*;
#(
    parameter  int DEPTH  = BLOCK_WORDS,
    parameter  int STRIDE = IL_STRIDE,
    parameter  int OFFSET = IL_OFFSET,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap,
    input  logic          filled_bank,
    input  logic          rd_en,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          fire,
    output chan_e         chan
);
    logic [AW-1:0] tbl [DEPTH];
    logic [AW-1:0] idx;
    logic          active;

    for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
        assign tbl[i] = AW'(il_addr(i, DEPTH, STRIDE, OFFSET));
    end

    assign rd_addr = tbl[idx];
    assign fire    = rd_en && active;
    assign chan    = chan_e'(idx[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            idx     <= '0;
            rd_bank <= 1'b1;
        end else if (swap) begin
            active  <= 1'b1;
            idx     <= '0;
            rd_bank <= filled_bank;
        end else if (fire) begin
            idx <= idx + AW'(1);
            if (idx == AW'(DEPTH - 1)) begin
                active <= 1'b0;
            end
        end
    end

    // R5
    drain_only_by_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(rd_en));

    // R11
    restart_on_swap_chk: assert property (@(posedge clk) disable iff (rst)
        swap |=> (active && idx == '0));

endmodule

// File: rtl/deint_pingpong.sv
module deint_pingpong
    import deint_pkg::*;
#(
    parameter  int WORD_W = SAMPLE_W,
    parameter  int DEPTH  = BLOCK_WORDS,
    parameter  int STRIDE = IL_STRIDE,
    parameter  int OFFSET = IL_OFFSET,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              blk_start,
    input  logic              rd_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              chan_b,
    output logic              blk_ready
);
    logic              wr_en, wr_bank_sel, wr_val, cur_bank, swap;
    logic [AW-1:0]     wr_word, rd_addr;
    logic [PW-1:0]     wr_pos;
    logic              rd_bank, fire;
    logic [WORD_W-1:0] rd_data;
    chan_e             chan;

    deint_wr_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .blk_start(blk_start), .wr_en(wr_en), .wr_bank_sel(wr_bank_sel),
        .wr_word(wr_word), .wr_pos(wr_pos), .wr_val(wr_val),
        .cur_bank(cur_bank), .swap(swap)
    );

    deint_bank_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_bank_sel(wr_bank_sel),
        .wr_word(wr_word), .wr_pos(wr_pos), .wr_val(wr_val),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    deint_rd_seq #(.DEPTH(DEPTH), .STRIDE(STRIDE), .OFFSET(OFFSET)) u_rd (
        .clk(clk), .rst(rst), .swap(swap), .filled_bank(cur_bank),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .fire(fire), .chan(chan)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_out   <= '0;
            word_valid <= 1'b0;
            chan_b     <= 1'b0;
            blk_ready  <= 1'b0;
        end else begin
            word_valid <= fire;
            blk_ready  <= swap;
            if (fire) begin
                word_out <= rd_data;
                chan_b   <= (chan == CH_B);
            end
        end
    end

    // R2
    banks_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        rd_bank != cur_bank);

    // R6
    ready_single_chk: assert property (@(posedge clk) disable iff (rst)
        blk_ready |=> !blk_ready);

    // R5
    word_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(rd_en));

    // R4
    chan_alternates_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && $past(fire) && !$past(swap)) |=> (chan_b != $past(chan_b)));

endmodule

// File: tb/tb_deint_pingpong.sv
module tb_deint_pingpong;
    localparam int CLK_P = 10;
    localparam int W     = 11;
    localparam int D     = 64;
    localparam int NB    = W * D;

    logic         clk = 1'b0;
    logic         rst, bit_valid, bit_in, blk_start, rd_en;
    logic [W-1:0] word_out;
    logic         word_valid, chan_b, blk_ready;

    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    deint_pingpong dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
        .blk_start(blk_start), .rd_en(rd_en), .word_out(word_out),
        .word_valid(word_valid), .chan_b(chan_b), .blk_ready(blk_ready)
    );

    function automatic logic bitval(input int seed, input int k);
        return logic'((((k * 37 + seed * 101) >> 2) ^ (k % 5 == seed % 5 ? 1 : 0)) & 1);
    endfunction

    function automatic logic [W-1:0] exp_word(input int seed, input int j);
        logic [W-1:0] r;
        int a;
        a = (23 * j + 5) % D;
        for (int b = 0; b < W; b++) r[b] = bitval(seed, b * D + a);
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic bv, input logic bi, input logic bs, input logic re);
        bit_valid = bv;
        bit_in    = bi;
        blk_start = bs;
        rd_en     = re;
        @(posedge clk);
        #2;
        bit_valid = 1'b0;
        bit_in    = 1'b0;
        blk_start = 1'b0;
        rd_en     = 1'b0;
    endtask

    task automatic check_word(input string req, input int seed, input int j);
        check({req, " valid"}, int'(word_valid), 1);
        check({req, " data"}, int'(word_out), int'(exp_word(seed, j)));
        check({req, " R4 chan"}, int'(chan_b), j % 2);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        bit_valid = 1'b0; bit_in = 1'b0; blk_start = 1'b0; rd_en = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R9 reset state
        check("R9 word_out", int'(word_out), 0);
        check("R9 word_valid", int'(word_valid), 0);
        check("R9 chan_b", int'(chan_b), 0);
        check("R9 blk_ready", int'(blk_ready), 0);

        // R7 read before any block
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 no early word", int'(word_valid), 0);

        // R7 partial block: no swap, no ready
        for (int k = 0; k < 100; k++) step(1'b1, ~bitval(1, k), 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R7 partial no ready", int'(blk_ready), 0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R7 partial no word", int'(word_valid), 0);

        // block seed 1 plus surplus bits (R8)
        for (int k = 0; k < NB; k++) step(1'b1, bitval(1, k), 1'b0, 1'b0);
        for (int k = 0; k < 9; k++) step(1'b1, ~bitval(1, k), 1'b0, 1'b0);
        check("R6 no ready before start", int'(blk_ready), 0);
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R6 ready pulse", int'(blk_ready), 1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R6 ready one cycle", int'(blk_ready), 0);

        // read block 1 on alternate cycles while writing block 2 (R1 R2 R3 R8)
        for (int c = 0; c < 128; c++) begin
            step(1'b1, bitval(2, c), 1'b0, (c % 2 == 0));
            if (c % 2 == 0) check_word("R1 R2 R3 R8 blk1", 1, c / 2);
            else check("R5 idle no word", int'(word_valid), 0);
        end
        // R5 exhausted
        for (int c = 128; c < NB; c++) begin
            step(1'b1, bitval(2, c), 1'b0, (c == 128));
            if (c == 128) check("R5 drained no word", int'(word_valid), 0);
        end

        // R10 bit with blk_start becomes bit 0 of block 3
        step(1'b1, bitval(3, 0), 1'b1, 1'b0);
        check("R6 ready blk2", int'(blk_ready), 1);
        for (int c = 1; c < NB; c++) begin
            step(1'b1, bitval(3, c), 1'b0, (c <= 10));
            if (c <= 10) check_word("R3 blk2", 2, c - 1);
        end

        // R11 swap mid-read restarts at word 0 of new bank
        step(1'b0, 1'b0, 1'b1, 1'b0);
        check("R11 ready blk3", int'(blk_ready), 1);
        for (int j = 0; j < D; j++) begin
            step(1'b0, 1'b0, 1'b0, 1'b1);
            check_word("R10 R11 blk3", 3, j);
        end
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R5 drained blk3", int'(word_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule